// File: doc/BRIEF.md
# Video Event Interrupt Generator

This block watches the timing of an incoming video stream and turns each event of interest into a sticky pending bit. The events are the two edges of the blanking level, the start of an even or odd field, a programmed line being reached, and one bit whose meaning depends on the operating mode. Each pending bit has an enable bit. A single interrupt line is raised whenever an enabled bit is pending. Software clears a bit by pulsing a one on its clear input.

The shared event bit has two meanings. In message mode it records a message-buffer swap, and a status bit keeps the identity of the buffer that was just filled. In video mode it records the count of outstanding ancillary packets climbing to a programmed, non-zero threshold. Field-start events are raised only for interlaced input. They are detected when blanking ends: the field identifier is compared with the one recorded at the previous end of blanking.

Top module: `vid_evt_irq`

## Requirements
- R1: On the first clock where the blanking level is high after being low, pending bit 0 (blanking start) is set and can be seen after that clock edge.
- R2: On the first clock where the blanking level is low after being high, pending bit 1 (blanking end) is set.
- R3: At a blanking end with interlaced mode on, a field-start bit is set when no field has been recorded since reset or the field identifier differs from the one recorded at the previous blanking end. The bit is bit 2 for identifier 0 (even) and bit 3 for identifier 1 (odd). Every blanking end records the identifier.
- R4: With interlaced mode off, bits 2 and 3 are never set.
- R5: Bit 4 is set once, on the clock where the line number becomes equal to the target line. It does not set again while the two stay equal.
- R6: In message mode, a buffer-swap strobe sets bit 5 and loads the buffer-select output from the buffer-id input. Threshold crossings have no effect in this mode.
- R7: In video mode, bit 5 is set once, on the clock where the packet count first becomes greater than or equal to a non-zero threshold. A zero threshold never fires. Swap strobes are ignored, and the buffer-select output keeps its value.
- R8: A one on a clear input clears its pending bit on the next edge. Pending bits otherwise stay set. When a set and a clear for the same bit arrive on the same clock, the bit ends up set.
- R9: The interrupt output is high exactly when some pending bit and its enable bit are both one.
- R10: Synchronous reset clears every pending bit, the buffer-select output and the recorded field state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_i | input | 1 | Vertical blanking level |
| field_id_i | input | 1 | Current field identifier (0 even, 1 odd) |
| interlaced_i | input | 1 | Interlaced input when high |
| line_num_i | input | LINE_W | Current line number |
| line_target_i | input | LINE_W | Programmed target line |
| anc_count_i | input | CNT_W | Outstanding ancillary packet count |
| anc_thresh_i | input | CNT_W | Programmed packet threshold (0 disables) |
| msg_mode_i | input | 1 | Message mode when high, video mode when low |
| buf_swap_i | input | 1 | Message-buffer swap strobe |
| buf_id_i | input | 1 | Identity of the buffer just filled |
| irq_en_i | input | 6 | Per-bit interrupt enable |
| clr_i | input | 6 | Per-bit clear strobe (write one to clear) |
| pending_o | output | 6 | Pending event bits |
| buf_sel_o | output | 1 | Last filled message buffer |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several properties on every cycle. Both blanking edges always land in their pending bits. Field bits stay quiet in progressive mode. A clear with no competing set empties the line bit, and a set bit that is not cleared stays set. The buffer select moves only on a swap in message mode, and the interrupt stays low when nothing is pending or nothing is enabled. Other behaviours need the bench's scenarios. These are the field-identity comparison across successive blanking ends, the single firing of the line and threshold conditions while they stay true, the zero-threshold case, the set-beats-clear collision, and the mode-dependent meaning of bit 5.

// File: rtl/vid_evt_pkg.sv
package vid_evt_pkg;

    localparam int NUM_EVT = 6;

    // Bit positions of the pending vector.
    localparam int B_VB_START = 0;
    localparam int B_VB_END   = 1;
    localparam int B_FLD_EVEN = 2;
    localparam int B_FLD_ODD  = 3;
    localparam int B_LINE_HIT = 4;
    localparam int B_SHARED   = 5;

    // Packed so that vb_start is bit 0.
    typedef struct packed {
        logic shared;
        logic line_hit;
        logic fld_odd;
        logic fld_even;
        logic vb_end;
        logic vb_start;
    } evt_vec_t;

    typedef enum logic {
        MODE_VIDEO = 1'b0,
        MODE_MSG   = 1'b1
    } op_mode_e;

    function automatic logic thresh_reached(input logic [31:0] cnt,
                                            input logic [31:0] thr);
        return (thr != 32'd0) && (cnt >= thr);
    endfunction

endpackage

// File: rtl/vid_evt_edges.sv
module vid_evt_edges #(
    parameter int              N       = 3,
    parameter logic [N-1:0]    RST_LVL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= RST_LVL[i];
            else     prev_q[i] <= lvl_i[i];
        end
        assign rise_o[i] = lvl_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/vid_evt_field.sv
module vid_evt_field (
    input  logic clk,
    input  logic rst,
    input  logic blank_end_i,
    input  logic field_id_i,
    input  logic interlaced_i,
    output logic even_o,
    output logic odd_o
);
    logic seen_q;
    logic last_q;
    logic change;

    assign change = blank_end_i & interlaced_i & (~seen_q | (field_id_i != last_q));
    assign even_o = change & ~field_id_i;
    assign odd_o  = change &  field_id_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= 1'b0;
        end else if (blank_end_i) begin
            seen_q <= 1'b1;
            last_q <= field_id_i;
        end
    end
endmodule

// File: rtl/vid_evt_pend.sv
module vid_evt_pend #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           pend_q[i] <= 1'b0;
            else if (set_i[i]) pend_q[i] <= 1'b1;
            else if (clr_i[i]) pend_q[i] <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/vid_evt_irq.sv
module vid_evt_irq
    import vid_evt_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vblank_i,
    input  logic                field_id_i,
    input  logic                interlaced_i,
    input  logic [LINE_W-1:0]   line_num_i,
    input  logic [LINE_W-1:0]   line_target_i,
    input  logic [CNT_W-1:0]    anc_count_i,
    input  logic [CNT_W-1:0]    anc_thresh_i,
    input  logic                msg_mode_i,
    input  logic                buf_swap_i,
    input  logic                buf_id_i,
    input  logic [NUM_EVT-1:0]  irq_en_i,
    input  logic [NUM_EVT-1:0]  clr_i,
    output logic [NUM_EVT-1:0]  pending_o,
    output logic                buf_sel_o,
    output logic                irq_o
);
    // Edge channels: 0 blank rise, 1 blank fall (inverted level), 2 line match, 3 threshold
    localparam int NCH = 4;
    localparam logic [NCH-1:0] CH_RST = 4'b0010;

    op_mode_e     mode;
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] rise;
    logic         line_eq;
    logic         reached;
    logic         fld_even;
    logic         fld_odd;
    evt_vec_t     evt;
    logic         buf_sel_q;

    assign mode    = op_mode_e'(msg_mode_i);
    assign line_eq = (line_num_i == line_target_i);
    assign reached = thresh_reached(32'(anc_count_i), 32'(anc_thresh_i));
    assign lvl     = {reached, line_eq, ~vblank_i, vblank_i};

    vid_evt_edges #(.N(NCH), .RST_LVL(CH_RST)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl),
        .rise_o (rise)
    );

    vid_evt_field u_field (
        .clk          (clk),
        .rst          (rst),
        .blank_end_i  (rise[1]),
        .field_id_i   (field_id_i),
        .interlaced_i (interlaced_i),
        .even_o       (fld_even),
        .odd_o        (fld_odd)
    );

    always_comb begin
        evt          = '0;
        evt.vb_start = rise[0];
        evt.vb_end   = rise[1];
        evt.fld_even = fld_even;
        evt.fld_odd  = fld_odd;
        evt.line_hit = rise[2];
        unique case (mode)
            MODE_MSG:   evt.shared = buf_swap_i;
            MODE_VIDEO: evt.shared = rise[3];
            default:    evt.shared = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                  buf_sel_q <= 1'b0;
        else if (mode == MODE_MSG && buf_swap_i)  buf_sel_q <= buf_id_i;
    end
    assign buf_sel_o = buf_sel_q;

    vid_evt_pend #(.N(NUM_EVT)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt),
        .clr_i  (clr_i),
        .en_i   (irq_en_i),
        .pend_o (pending_o),
        .irq_o  (irq_o)
    );
endmodule

// File: rtl/vid_evt_irq_chk.sv
module vid_evt_irq_chk #(
    parameter int LINE_W = 11,
    parameter int N      = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              vblank_i,
    input logic              interlaced_i,
    input logic [LINE_W-1:0] line_num_i,
    input logic [LINE_W-1:0] line_target_i,
    input logic              msg_mode_i,
    input logic              buf_swap_i,
    input logic [N-1:0]      irq_en_i,
    input logic [N-1:0]      clr_i,
    input logic [N-1:0]      pending_o,
    input logic              buf_sel_o,
    input logic              irq_o
);
    assert_vb_start_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && vblank_i && !$past(vblank_i)) |=> pending_o[0]);

    assert_vb_end_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !vblank_i && $past(vblank_i)) |=> pending_o[1]);

    assert_no_even_R4: assert property (@(posedge clk) disable iff (rst)
        (!interlaced_i && !pending_o[2]) |=> !pending_o[2]);

    assert_no_odd_R4: assert property (@(posedge clk) disable iff (rst)
        (!interlaced_i && !pending_o[3]) |=> !pending_o[3]);

    assert_line_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_i[4] && (line_num_i != line_target_i)) |=> !pending_o[4]);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (pending_o[0] && !clr_i[0]) |=> pending_o[0]);

    assert_bsel_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(msg_mode_i && buf_swap_i) |=> $stable(buf_sel_o));

    assert_irq_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (pending_o == '0) |-> !irq_o);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == '0) |-> !irq_o);
endmodule

bind vid_evt_irq vid_evt_irq_chk #(.LINE_W(LINE_W), .N(vid_evt_pkg::NUM_EVT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .vblank_i      (vblank_i),
    .interlaced_i  (interlaced_i),
    .line_num_i    (line_num_i),
    .line_target_i (line_target_i),
    .msg_mode_i    (msg_mode_i),
    .buf_swap_i    (buf_swap_i),
    .irq_en_i      (irq_en_i),
    .clr_i         (clr_i),
    .pending_o     (pending_o),
    .buf_sel_o     (buf_sel_o),
    .irq_o         (irq_o)
);

// File: tb/tb_vid_evt_irq.sv
module tb_vid_evt_irq;
    localparam int LW = 11;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          vblank, field_id, interlaced, msg_mode, buf_swap, buf_id;
    logic [LW-1:0] line_num, line_tgt;
    logic [CW-1:0] anc_cnt, anc_thr;
    logic [5:0]    en, clr;
    logic [5:0]    pending;
    logic          buf_sel, irq;

    vid_evt_irq #(.LINE_W(LW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .vblank_i(vblank), .field_id_i(field_id),
        .interlaced_i(interlaced), .line_num_i(line_num), .line_target_i(line_tgt),
        .anc_count_i(anc_cnt), .anc_thresh_i(anc_thr), .msg_mode_i(msg_mode),
        .buf_swap_i(buf_swap), .buf_id_i(buf_id), .irq_en_i(en), .clr_i(clr),
        .pending_o(pending), .buf_sel_o(buf_sel), .irq_o(irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R10";

    // Reference model state
    bit m_pend[6];
    bit m_bsel, m_pvb, m_pvb_vld, m_pmatch, m_preach, m_fseen, m_flast;

    task automatic model_update();
        bit s[6];
        bit match, reach;
        for (int i = 0; i < 6; i++) s[i] = 0;
        if (rst) begin
            for (int i = 0; i < 6; i++) m_pend[i] = 0;
            m_bsel = 0; m_pvb = 0; m_pvb_vld = 0; m_pmatch = 0; m_preach = 0;
            m_fseen = 0; m_flast = 0;
            return;
        end
        if (vblank && !m_pvb) s[0] = 1;
        if (!vblank && m_pvb) begin
            s[1] = 1;
            if (interlaced && (!m_fseen || field_id != m_flast)) begin
                if (field_id) s[3] = 1; else s[2] = 1;
            end
            m_fseen = 1;
            m_flast = field_id;
        end
        match = (line_num == line_tgt);
        if (match && !m_pmatch) s[4] = 1;
        reach = (anc_thr != 0) && (int'(anc_cnt) >= int'(anc_thr));
        if (msg_mode) begin
            if (buf_swap) begin s[5] = 1; m_bsel = buf_id; end
        end else if (reach && !m_preach) s[5] = 1;
        for (int i = 0; i < 6; i++)
            m_pend[i] = s[i] ? 1'b1 : (clr[i] ? 1'b0 : m_pend[i]);
        m_pvb = vblank; m_pmatch = match; m_preach = reach;
    endtask

    task automatic compare();
        logic [5:0] exp_p;
        bit exp_irq;
        exp_irq = 0;
        for (int i = 0; i < 6; i++) begin
            exp_p[i] = m_pend[i];
            if (m_pend[i] && en[i]) exp_irq = 1;
        end
        n_tests++;
        if (pending !== exp_p || buf_sel !== m_bsel || irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s: pending=%b buf_sel=%b irq=%b expected pending=%b buf_sel=%b irq=%b",
                     cur_req, pending, buf_sel, irq, exp_p, m_bsel, exp_irq);
        end
    endtask

    task automatic step(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_update();
            #1;
            compare();
            clr = '0;
            buf_swap = 1'b0;
        end
    endtask

    task automatic blank_pulse(bit fid);
        field_id = fid;
        vblank = 1'b1; step(3);
        vblank = 1'b0; step(3);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; vblank = 0; field_id = 0; interlaced = 0; msg_mode = 0;
        buf_swap = 0; buf_id = 0; line_num = '0; line_tgt = 11'd10;
        anc_cnt = '0; anc_thr = '0; en = '0; clr = '0;
        // R10: reset state, including with busy inputs
        cur_req = "R10";
        vblank = 1; msg_mode = 1; buf_swap = 1; buf_id = 1;
        step(3);
        vblank = 0; msg_mode = 0;
        step(1);
        rst = 1'b0;
        step(2);

        // R1 / R2: blanking edges
        cur_req = "R1"; vblank = 1; step(3);
        cur_req = "R2"; vblank = 0; step(3);

        // R9: enables steer the interrupt
        cur_req = "R9";
        en = 6'b000001; step(2);
        en = 6'b000010; step(1);
        en = 6'b111100; step(2);
        en = 6'b111111; step(1);

        // R8: clear, then set-beats-clear
        cur_req = "R8";
        clr = 6'b000011; step(2);
        vblank = 1; clr = 6'b000001; step(2);
        clr = 6'b000001; step(1);
        vblank = 0; step(1);
        clr = 6'b111111; step(1);

        // R3: interlaced field detection
        cur_req = "R3"; interlaced = 1;
        blank_pulse(1);
        blank_pulse(0);
        clr = 6'b111111; step(1);
        blank_pulse(0);
        blank_pulse(1);
        clr = 6'b111111; step(1);

        // R4: progressive input gives no field events
        cur_req = "R4"; interlaced = 0;
        blank_pulse(0);
        blank_pulse(1);
        blank_pulse(0);
        clr = 6'b111111; step(1);

        // R5: line match fires once per arrival
        cur_req = "R5";
        for (int l = 0; l < 16; l++) begin
            line_num = LW'(l); step(1);
            if (l == 11) begin clr = 6'b010000; end
        end
        line_num = 11'd10; step(4);
        clr = 6'b010000; step(3);
        line_tgt = 11'd12; step(1);
        line_num = 11'd12; step(2);
        clr = 6'b111111; step(1);

        // R6: message mode swaps, threshold ignored
        cur_req = "R6"; msg_mode = 1; anc_thr = 8'd4;
        anc_cnt = 8'd6; step(2);
        buf_swap = 1; buf_id = 1; step(2);
        clr = 6'b100000; step(1);
        buf_swap = 1; buf_id = 0; step(2);
        anc_cnt = 8'd0; step(1);
        clr = 6'b111111; step(1);

        // R7: video mode threshold, swaps ignored
        cur_req = "R7"; msg_mode = 1; buf_swap = 1; buf_id = 1; step(1);
        msg_mode = 0; clr = 6'b111111; step(1);
        for (int c = 0; c < 8; c++) begin
            anc_cnt = CW'(c); step(1);
        end
        clr = 6'b100000; step(3);
        buf_swap = 1; buf_id = 0; step(2);
        anc_cnt = 8'd1; step(2);
        anc_cnt = 8'd9; step(2);
        clr = 6'b100000; step(1);
        anc_thr = 8'd0; anc_cnt = 8'd0; step(1);
        anc_cnt = 8'd200; step(3);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule